// File: doc/BRIEF.md
# Dual-Channel Converter Register Load Sequencer

This block writes a pair of 12-bit sample words into two external edge-triggered holding registers. Each register feeds its own D/A converter. Both registers listen to one shared 12-bit data bus, and each one has a separate clock strobe. The block drives the bus and both strobes from a single output register, so a data change and a strobe change always land in the same clock edge.

A sample pair is offered with a one-cycle start pulse. It is accepted only while the sequencer is idle. The block then steps through five bus phases:

1. Channel 1 word on the bus, both strobes low.
2. The same word with strobe 1 high.
3. Channel 2 word on the bus, both strobes low.
4. The same word with strobe 2 high.
5. Both strobes low again.

Each phase lasts a programmable number of clock cycles, so the register setup time can be met. A one-cycle done pulse marks the end of the sequence. Between sequences the bus keeps the last word it drove. The external registers therefore only ever see wanted values.

Top module: `dac_pair_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both strobes are low, the bus is zero, busy is low and done is low.
- R2: A start pulse is taken only while busy is low. A start pulse while busy is high does not change the words, the phase length or the timing of the running sequence.
- R3: The cycle after an accepted start, the bus carries the channel 1 word with both strobes low. Next comes a phase with the same word and strobe 1 high.
- R4: After the channel 1 phases, the bus carries the channel 2 word with both strobes low. Next comes a phase with the same word and strobe 2 high. Each channel gets its own full 12-bit word.
- R5: The fifth phase keeps the channel 2 word on the bus with both strobes low.
- R6: Each of the five phases lasts L cycles. L is the value of the phase length input at the accepted start, with 0 treated as 1. Busy is high for exactly 5*L cycles.
- R7: While either strobe is high, including the cycle it rises, the bus holds the value it had in the cycle before.
- R8: The two strobes are never high in the same cycle.
- R9: Done is high for exactly one cycle, in the first cycle after the fifth phase ends, which is also the first cycle busy is low.
- R10: While idle, the bus keeps the last word driven and the strobes stay low, whatever the sample and length inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Offers a sample pair for one cycle |
| word_ch1_i | input | 12 | Sample word for channel 1 |
| word_ch2_i | input | 12 | Sample word for channel 2 |
| phase_len_i | input | 8 | Cycles per bus phase (0 acts as 1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| bus_o | output | 12 | Shared data bus to both registers |
| strobe1_o | output | 1 | Clock strobe of channel 1 register |
| strobe2_o | output | 1 | Clock strobe of channel 2 register |

## Verification
The assertions assume start is a synchronous pulse, and that the word and length inputs matter only in the cycle a start is taken. Nothing in the checks constrains those inputs at other times. The stimulus changes inputs on the falling clock edge only, which keeps within that assumption. It also deliberately waves new words, new lengths and extra starts while a sequence runs and while idle, to show they are ignored. Phase lengths of 0, 1, 3 and 5 are used so that the count boundary and the zero-as-one rule are both exercised.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_A_SET = 3'd1,
    ST_A_STB = 3'd2,
    ST_B_SET = 3'd3,
    ST_B_STB = 3'd4,
    ST_FIN   = 3'd5
  } seq_state_t;

  // Fixed phase order of one load sequence
  function automatic seq_state_t phase_after(seq_state_t s);
    case (s)
      ST_A_SET: phase_after = ST_A_STB;
      ST_A_STB: phase_after = ST_B_SET;
      ST_B_SET: phase_after = ST_B_STB;
      ST_B_STB: phase_after = ST_FIN;
      default:  phase_after = ST_IDLE;
    endcase
  endfunction

  // Strobe pair {strobe2, strobe1} presented during a phase
  function automatic logic [1:0] strobes_of(seq_state_t s);
    case (s)
      ST_A_STB: strobes_of = 2'b01;
      ST_B_STB: strobes_of = 2'b10;
      default:  strobes_of = 2'b00;
    endcase
  endfunction

  // True when the phase shows the channel 2 word on the bus
  function automatic logic shows_ch2(seq_state_t s);
    shows_ch2 = (s == ST_B_SET) || (s == ST_B_STB) || (s == ST_FIN);
  endfunction

endpackage

// File: rtl/dpl_phase_timer.sv
module dpl_phase_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             running_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             phase_end_o
);
  // Effective phase length: zero is promoted to one
  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] raw);
    eff_len = (raw == '0) ? LEN_W'(1) : raw;
  endfunction

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  assign phase_end_o = running_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= LEN_W'(1);
      cnt_q <= '0;
    end else if (accept_i) begin
      len_q <= eff_len(len_i);
      cnt_q <= eff_len(len_i) - LEN_W'(1);
    end else if (phase_end_o) begin
      cnt_q <= len_q - LEN_W'(1);
    end else if (running_i) begin
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) && (cnt_q < len_q));

endmodule

// File: rtl/dpl_sample_store.sv
module dpl_sample_store #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] ch1_i,
  input  logic [DATA_W-1:0] ch2_i,
  output logic [DATA_W-1:0] ch1_q,
  output logic [DATA_W-1:0] ch2_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch1_q <= '0;
      ch2_q <= '0;
    end else if (accept_i) begin
      ch1_q <= ch1_i;
      ch2_q <= ch2_i;
    end
  end

  assert_words_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept_i) |-> ($stable(ch1_q) && $stable(ch2_q)));

endmodule

// File: rtl/dpl_seq_fsm.sv
module dpl_seq_fsm
  import dpl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       phase_end_i,
  output logic       accept_o,
  output seq_state_t state_o,
  output seq_state_t state_next_o,
  output logic       busy_o,
  output logic       done_o
);
  seq_state_t state_q;
  logic       done_q;

  assign accept_o = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_next_o = state_q;
    if (accept_o)         state_next_o = ST_A_SET;
    else if (phase_end_i) state_next_o = phase_after(state_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_next_o;
      done_q  <= (state_q == ST_FIN) && phase_end_i;
    end
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_from_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(state_q) == ST_FIN) && !busy_o);

  assert_idle_only_after_finish_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || $past(state_q) == ST_FIN));

endmodule

// File: rtl/dpl_bus_driver.sv
module dpl_bus_driver
  import dpl_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  seq_state_t        state_next_i,
  input  logic [DATA_W-1:0] ch1_in_i,
  input  logic [DATA_W-1:0] ch1_q_i,
  input  logic [DATA_W-1:0] ch2_q_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              strobe1_o,
  output logic              strobe2_o
);
  logic [DATA_W-1:0] bus_d;
  logic [1:0]        stb_d;
  logic [DATA_W-1:0] bus_q;
  logic [1:0]        stb_q;

  // One combined word: bus and strobes are registered together
  always_comb begin
    stb_d = strobes_of(state_next_i);
    if (accept_i)                     bus_d = ch1_in_i;
    else if (state_next_i == ST_IDLE) bus_d = bus_q;
    else if (shows_ch2(state_next_i)) bus_d = ch2_q_i;
    else                              bus_d = ch1_q_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_q <= '0;
      stb_q <= 2'b00;
    end else begin
      bus_q <= bus_d;
      stb_q <= stb_d;
    end
  end

  assign bus_o     = bus_q;
  assign strobe1_o = stb_q[0];
  assign strobe2_o = stb_q[1];

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe1_o && strobe2_o));

  assert_data_before_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe1_o || strobe2_o) |-> $stable(bus_o));

endmodule

// File: rtl/dac_pair_loader.sv
module dac_pair_loader
  import dpl_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_ch1_i,
  input  logic [DATA_W-1:0] word_ch2_i,
  input  logic [LEN_W-1:0]  phase_len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              strobe1_o,
  output logic              strobe2_o
);
  // Named internal events, visible to the assertions
  logic              accept_w;
  logic              phase_end_w;
  logic              running_w;
  seq_state_t        state_w;
  seq_state_t        state_next_w;
  logic [DATA_W-1:0] ch1_q_w;
  logic [DATA_W-1:0] ch2_q_w;

  assign running_w = busy_o;

  dpl_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .phase_end_i  (phase_end_w),
    .accept_o     (accept_w),
    .state_o      (state_w),
    .state_next_o (state_next_w),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  dpl_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept_w),
    .running_i   (running_w),
    .len_i       (phase_len_i),
    .phase_end_o (phase_end_w)
  );

  dpl_sample_store #(.DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept_w),
    .ch1_i    (word_ch1_i),
    .ch2_i    (word_ch2_i),
    .ch1_q    (ch1_q_w),
    .ch2_q    (ch2_q_w)
  );

  dpl_bus_driver #(.DATA_W(DATA_W)) u_drv (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept_w),
    .state_next_i (state_next_w),
    .ch1_in_i     (word_ch1_i),
    .ch1_q_i      (ch1_q_w),
    .ch2_q_i      (ch2_q_w),
    .bus_o        (bus_o),
    .strobe1_o    (strobe1_o),
    .strobe2_o    (strobe2_o)
  );

  assert_idle_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> ($stable(bus_o) && !strobe1_o && !strobe2_o));

  assert_strobe_ch1_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe1_o |-> (bus_o == ch1_q_w) && (state_w == ST_A_STB));

  assert_strobe_ch2_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe2_o |-> (bus_o == ch2_q_w) && (state_w == ST_B_STB));

endmodule

// File: tb/tb_dac_pair_loader.sv
module tb_dac_pair_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [11:0] word_ch1_i, word_ch2_i;
  logic [7:0]  phase_len_i;
  logic        busy_o, done_o, strobe1_o, strobe2_o;
  logic [11:0] bus_o;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dac_pair_loader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .word_ch1_i(word_ch1_i), .word_ch2_i(word_ch2_i), .phase_len_i(phase_len_i),
    .busy_o(busy_o), .done_o(done_o), .bus_o(bus_o),
    .strobe1_o(strobe1_o), .strobe2_o(strobe2_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b1; word_ch1_i = 12'hABC; word_ch2_i = 12'h123; phase_len_i = 8'd2;
    repeat (3) @(negedge clk);
    chk("R1", "strobe1 in reset", strobe1_o, 0);
    chk("R1", "strobe2 in reset", strobe2_o, 0);
    chk("R1", "bus in reset", bus_o, 0);
    chk("R1", "busy in reset", busy_o, 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "bus after reset", bus_o, 0);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "busy after reset", busy_o, 0);
  endtask

  // One full load; optional interference with a start while busy
  task automatic run_pair(input logic [11:0] a, input logic [11:0] b,
                          input logic [7:0] len, input bit meddle);
    int L;
    int prev_bus;
    L = (len == 0) ? 1 : int'(len);
    @(negedge clk);
    word_ch1_i = a; word_ch2_i = b; phase_len_i = len; start_i = 1'b1;
    prev_bus = int'(bus_o);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= 5 * L; k++) begin
      int ph;
      int eb, e1, e2;
      string rq;
      ph = (k - 1) / L;
      eb = (ph < 2) ? int'(a) : int'(b);
      e1 = (ph == 1) ? 1 : 0;
      e2 = (ph == 3) ? 1 : 0;
      rq = (ph < 2) ? "R3" : ((ph < 4) ? "R4" : "R5");
      chk(rq, "bus word", bus_o, eb);
      chk(rq, "strobe1", strobe1_o, e1);
      chk(rq, "strobe2", strobe2_o, e2);
      chk("R6", "busy during phases", busy_o, 1);
      chk("R9", "done during phases", done_o, 0);
      chk("R8", "both strobes", int'(strobe1_o && strobe2_o), 0);
      if (strobe1_o || strobe2_o) chk("R7", "bus moved with strobe", bus_o, prev_bus);
      prev_bus = int'(bus_o);
      if (meddle && (k == 2 || k == 3 * L)) begin
        start_i = 1'b1; word_ch1_i = ~a; word_ch2_i = ~b; phase_len_i = len + 8'd3;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R9", "done at end", done_o, 1);
    chk("R6", "busy at end", busy_o, 0);
    chk("R10", "bus at end", bus_o, b);
    @(negedge clk);
    chk("R9", "done second cycle", done_o, 0);
    chk("R2", "no sequence from busy start", busy_o, 0);
    chk("R10", "bus held", bus_o, b);
  endtask

  task automatic idle_hold(input logic [11:0] held);
    for (int k = 0; k < 6; k++) begin
      word_ch1_i = 12'(k * 12'h111); word_ch2_i = ~word_ch1_i; phase_len_i = 8'(k);
      @(negedge clk);
      chk("R10", "idle bus", bus_o, held);
      chk("R10", "idle strobes", int'({strobe2_o, strobe1_o}), 0);
      chk("R10", "idle busy", busy_o, 0);
    end
  endtask

  initial begin
    do_reset();
    run_pair(12'hA5C, 12'h3F1, 8'd1, 1'b0);
    run_pair(12'hFFF, 12'h000, 8'd3, 1'b0);
    idle_hold(12'h000);
    run_pair(12'h800, 12'h001, 8'd0, 1'b0);
    run_pair(12'h5A5, 12'hC3C, 8'd5, 1'b1);
    run_pair(12'h0F0, 12'h70E, 8'd1, 1'b1);
    idle_hold(12'h70E);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule